// File: doc/BRIEF.md
# March X Memory Self-Test Engine

This block is a built-in self-test sequencer for a synchronous, word-wide RAM. A pulse on `start` captures a base address and a cell count. The engine then runs the four March X passes over that window. First it clears every cell going upward. Next, going upward again, it reads each cell, expects zero and writes all-ones. Then, going downward from the top of the window, it reads each cell, expects all-ones and writes zero. Last, going downward again, it only reads, expecting zero. The direction reversals, and the read-then-write visit to each cell in the two middle passes, expose stuck bits and coupling faults whose aggressor lies on either side of its victim.

Each comparison XORs the expected background with the returned word. The result is ORed into a sticky fault map, where bit i stands for RAM data bit i. The first mismatch ends the run at once. The engine drives the RAM directly through address, write data, write enable and read enable. Read data must arrive exactly one cycle after the read enable.

Top module: `march_bist_ctrl`

## Requirements
- R1: After an accepted start with length N>0, the first N memory accesses are writes of 0x00 to addresses base, base+1, …, base+N-1, one per cycle, with no reads among them.
- R2: The second pass visits base up to base+N-1. For each cell it issues a read, takes the returned data one cycle later and compares it with 0x00. In that comparison cycle it writes 0xFF to the same address. A read enable is never high in two consecutive cycles.
- R3: The third pass visits base+N-1 down to base. For each cell it reads, expects 0xFF, and writes 0x00 to the same address in the comparison cycle.
- R4: The fourth pass visits base+N-1 down to base with reads only, each expecting 0x00. A fault-free run therefore makes exactly 6N accesses and leaves every window cell at 0x00.
- R5: Every access falls inside the window, and read and write enables are never high together. On a fault-free run, `done` is first seen high after 7N+1 rising edges, counting the edge that samples `start`.
- R6: On the first mismatch, the mismatching cell is not written and no further access is made. `done` rises at the next edge with `fail` high. A mismatch at the j-th cell of the second pass gives `done` after N+2j+3 edges, and a mismatch at the j-th cell of the third pass gives `done` after 3N+2j+3 edges (j counted from 0).
- R7: `fault_map` gathers, by OR, the XOR of expected and read data. Bit i is data bit i. It never loses a set bit during a run.
- R8: A start seen while idle clears `fault_map` and `fail` at that edge. A start seen while busy has no effect on the access sequence or the run length.
- R9: A length of 0 makes `done` high after a single edge, with `fail` low and no memory access.
- R10: After reset, `busy`, `done`, `fail` and `fault_map` are 0. `done` is a one-cycle pulse and is never high together with `busy`. `fail` and `fault_map` hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a test run (taken only when idle) |
| win_base | input | AW | First address of the window |
| win_len | input | AW | Number of cells in the window |
| mem_addr | output | AW | RAM address |
| mem_wdata | output | DW | RAM write data |
| mem_we | output | 1 | RAM write enable |
| mem_re | output | 1 | RAM read enable |
| mem_rdata | input | DW | RAM read data, valid one cycle after `mem_re` |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle end-of-run pulse |
| fail | output | 1 | A mismatch was found in the last run |
| fault_map | output | DW | Accumulated failing data bits |

## Verification
Each result of a run is due at a fixed count of edges after the edge that samples `start`. A clean run ends after 7N+1 edges. An aborted run ends after N+2j+3 edges or 3N+2j+3 edges, depending on which pass fails. A zero-length run ends after one edge. The bench drives `start` at a falling edge and counts rising edges until it sees `done` at a falling edge. It compares that count with the formula, then reads `fail` and `fault_map` in the same sample and again one cycle later to confirm they hold. A monitor samples every access at the falling edge and matches it in order against a sequence computed from base and length.

// File: rtl/mbist_pkg.sv
package mbist_pkg;
   typedef enum logic [2:0] {
      S_IDLE,
      S_WR,
      S_RD,
      S_CMP,
      S_DONE
   } mb_state_t;

   typedef enum logic [1:0] {
      PH_FILL,
      PH_UP,
      PH_DN,
      PH_CHK
   } mb_phase_t;
endpackage

// File: rtl/mbist_addr_gen.sv
module mbist_addr_gen #(
   parameter int AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld_up,
   input  logic          ld_dn,
   input  logic          step,
   input  logic          dn,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] len,
   output logic [AW-1:0] addr,
   output logic          last
);
   localparam logic [AW-1:0] ONE = AW'(1);

   logic [AW-1:0] addr_q;
   logic [AW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         cnt_q  <= '0;
      end else if (ld_up) begin
         addr_q <= base;
         cnt_q  <= len;
      end else if (ld_dn) begin
         addr_q <= base + len - ONE;
         cnt_q  <= len;
      end else if (step) begin
         addr_q <= dn ? addr_q - ONE : addr_q + ONE;
         cnt_q  <= cnt_q - ONE;
      end
   end

   assign addr = addr_q;
   assign last = (cnt_q == ONE);
endmodule

// File: rtl/mbist_cmp.sv
module mbist_cmp #(
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          chk,
   input  logic [DW-1:0] expd,
   input  logic [DW-1:0] rdata,
   output logic          miss,
   output logic [DW-1:0] fmap
);
   logic [DW-1:0] diff;
   logic [DW-1:0] fmap_q;

   for (genvar b = 0; b < DW; b++) begin : g_bit
      assign diff[b] = expd[b] ^ rdata[b];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fmap_q <= '0;
      else if (clr)
         fmap_q <= '0;
      else if (chk)
         fmap_q <= fmap_q | diff;
   end

   assign miss = chk && (diff != '0);
   assign fmap = fmap_q;
endmodule

// File: rtl/march_bist_ctrl.sv
module march_bist_ctrl
   import mbist_pkg::*;
#(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic [AW-1:0] win_base,
   input  logic [AW-1:0] win_len,
   output logic [AW-1:0] mem_addr,
   output logic [DW-1:0] mem_wdata,
   output logic          mem_we,
   output logic          mem_re,
   input  logic [DW-1:0] mem_rdata,
   output logic          busy,
   output logic          done,
   output logic          fail,
   output logic [DW-1:0] fault_map
);
   localparam logic [DW-1:0] BG_ZERO = '0;
   localparam logic [DW-1:0] BG_ONES = '1;

   if (AW < 2 || AW > 32) begin : g_bad_aw
      $error("march_bist_ctrl: AW must lie in 2..32");
   end
   if (DW < 1 || DW > 64) begin : g_bad_dw
      $error("march_bist_ctrl: DW must lie in 1..64");
   end

   mb_state_t st_q, st_d;
   mb_phase_t ph_q, ph_d;
   logic [AW-1:0] base_q, len_q;
   logic          fail_q;

   logic          ld_up, ld_dn, step, dn, last, chk, clr, miss;
   logic [AW-1:0] base_sel, len_sel;
   logic [DW-1:0] expd;

   assign base_sel = (st_q == S_IDLE) ? win_base : base_q;
   assign len_sel  = (st_q == S_IDLE) ? win_len  : len_q;
   assign dn       = (ph_q == PH_DN) || (ph_q == PH_CHK);
   assign expd     = (ph_q == PH_DN) ? BG_ONES : BG_ZERO;

   always_comb begin
      st_d      = st_q;
      ph_d      = ph_q;
      ld_up     = 1'b0;
      ld_dn     = 1'b0;
      step      = 1'b0;
      chk       = 1'b0;
      clr       = 1'b0;
      mem_we    = 1'b0;
      mem_re    = 1'b0;
      mem_wdata = BG_ZERO;
      unique case (st_q)
         S_IDLE: begin
            if (start) begin
               clr   = 1'b1;
               ld_up = 1'b1;
               ph_d  = PH_FILL;
               st_d  = (win_len == '0) ? S_DONE : S_WR;
            end
         end
         S_WR: begin
            mem_we = 1'b1;
            if (last) begin
               ld_up = 1'b1;
               ph_d  = PH_UP;
               st_d  = S_RD;
            end else begin
               step = 1'b1;
            end
         end
         S_RD: begin
            mem_re = 1'b1;
            st_d   = S_CMP;
         end
         S_CMP: begin
            chk = 1'b1;
            if (miss) begin
               st_d = S_DONE;
            end else begin
               mem_we    = (ph_q != PH_CHK);
               mem_wdata = (ph_q == PH_UP) ? BG_ONES : BG_ZERO;
               st_d      = S_RD;
               if (!last) begin
                  step = 1'b1;
               end else if (ph_q == PH_UP) begin
                  ld_dn = 1'b1;
                  ph_d  = PH_DN;
               end else if (ph_q == PH_DN) begin
                  ld_dn = 1'b1;
                  ph_d  = PH_CHK;
               end else begin
                  st_d = S_DONE;
               end
            end
         end
         S_DONE: st_d = S_IDLE;
         default: st_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= S_IDLE;
         ph_q   <= PH_FILL;
         base_q <= '0;
         len_q  <= '0;
         fail_q <= 1'b0;
      end else begin
         st_q <= st_d;
         ph_q <= ph_d;
         if (clr) begin
            base_q <= win_base;
            len_q  <= win_len;
            fail_q <= 1'b0;
         end else if (miss) begin
            fail_q <= 1'b1;
         end
      end
   end

   mbist_addr_gen #(.AW(AW)) i_addr (
      .clk   (clk),
      .rst_n (rst_n),
      .ld_up (ld_up),
      .ld_dn (ld_dn),
      .step  (step),
      .dn    (dn),
      .base  (base_sel),
      .len   (len_sel),
      .addr  (mem_addr),
      .last  (last)
   );

   mbist_cmp #(.DW(DW)) i_cmp (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .chk   (chk),
      .expd  (expd),
      .rdata (mem_rdata),
      .miss  (miss),
      .fmap  (fault_map)
   );

   assign busy = (st_q == S_WR) || (st_q == S_RD) || (st_q == S_CMP);
   assign done = (st_q == S_DONE);
   assign fail = fail_q;
endmodule

// File: rtl/march_bist_chk.sv
module march_bist_chk #(
   parameter int AW = 16,
   parameter int DW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start,
   input logic [AW-1:0] mem_addr,
   input logic          mem_we,
   input logic          mem_re,
   input logic          busy,
   input logic          done,
   input logic          fail,
   input logic [DW-1:0] fault_map,
   input logic [AW-1:0] base_q,
   input logic [AW-1:0] len_q
);
   logic in_win;
   assign in_win = ({1'b0, mem_addr} >= {1'b0, base_q}) &&
                   ({1'b0, mem_addr} <  ({1'b0, base_q} + {1'b0, len_q}));

   a_r2_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
      mem_re |=> !mem_re);

   a_r5_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we || mem_re) |-> in_win);

   a_r5_no_rw_clash: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_we && mem_re));

   a_r6_quiet_at_end: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mem_we && !mem_re));

   a_r6_fail_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail) |-> done);

   a_r7_map_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ((fault_map & $past(fault_map)) == $past(fault_map)));

   a_r8_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy && !done) |=> (fault_map == '0 && !fail));

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));
endmodule

bind march_bist_ctrl march_bist_chk #(.AW(AW), .DW(DW)) i_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .mem_addr  (mem_addr),
   .mem_we    (mem_we),
   .mem_re    (mem_re),
   .busy      (busy),
   .done      (done),
   .fail      (fail),
   .fault_map (fault_map),
   .base_q    (base_q),
   .len_q     (len_q)
);

// File: tb/test_march_bist_ctrl.sv
module test_march_bist_ctrl;
   localparam int AW = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] win_base = '0;
   logic [AW-1:0] win_len = '0;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_wdata;
   logic          mem_we, mem_re;
   logic [DW-1:0] mem_rdata;
   logic          busy, done, fail;
   logic [DW-1:0] fault_map;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   march_bist_ctrl #(.AW(AW), .DW(DW)) i_march_bist_ctrl (
      .clk(clk), .rst_n(rst_n), .start(start), .win_base(win_base), .win_len(win_len),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_re(mem_re),
      .mem_rdata(mem_rdata), .busy(busy), .done(done), .fail(fail), .fault_map(fault_map)
   );

   // RAM model with injectable faults
   logic [7:0] ram [256];
   logic [7:0] flt_addr = 8'h00;
   logic [7:0] st0 = 8'h00, st1 = 8'h00;
   logic       cpl_en = 1'b0;
   logic [7:0] cpl_agg = 8'h00, cpl_vic = 8'h00;
   logic [7:0] rd_q = 8'h00;
   assign mem_rdata = rd_q;

   always @(posedge clk) begin
      if (mem_we) begin
         ram[mem_addr[7:0]] <= mem_wdata;
         if (cpl_en && mem_addr[7:0] == cpl_agg) ram[cpl_vic] <= mem_wdata;
      end
      if (mem_re) begin
         if (mem_addr[7:0] == flt_addr) rd_q <= (ram[mem_addr[7:0]] | st1) & ~st0;
         else rd_q <= ram[mem_addr[7:0]];
      end
   end

   // Access monitor
   int mon_k = 0;
   int seq_err = 0;
   int out_win = 0;
   int cur_s = 0, cur_n = 0;

   function automatic logic [25:0] exp_acc(input int k, input int s, input int n);
      int k2, j;
      if (k < n) return {2'd1, 16'(s + k), 8'h00};
      k2 = k - n;
      if (k2 < 2 * n) begin
         j = k2 / 2;
         return (k2 % 2 == 0) ? {2'd2, 16'(s + j), 8'h00} : {2'd1, 16'(s + j), 8'hFF};
      end
      k2 = k2 - 2 * n;
      if (k2 < 2 * n) begin
         j = k2 / 2;
         return (k2 % 2 == 0) ? {2'd2, 16'(s + n - 1 - j), 8'h00}
                              : {2'd1, 16'(s + n - 1 - j), 8'h00};
      end
      k2 = k2 - 2 * n;
      return {2'd2, 16'(s + n - 1 - k2), 8'h00};
   endfunction

   always @(negedge clk) begin
      if (rst_n && (mem_we || mem_re)) begin
         logic [25:0] e;
         logic [1:0]  op;
         e  = exp_acc(mon_k, cur_s, cur_n);
         op = mem_we ? 2'd1 : 2'd2;
         if (op != e[25:24] || mem_addr != e[23:8] || (mem_we && mem_wdata != e[7:0]))
            seq_err++;
         if (int'(mem_addr) < cur_s || int'(mem_addr) >= cur_s + cur_n) out_win++;
         mon_k++;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
      end
   endtask

   task automatic init_ram();
      for (int i = 0; i < 256; i++) ram[i] = 8'h5A;
      st0 = 8'h00; st1 = 8'h00; cpl_en = 1'b0;
   endtask

   // pulse start, return edges until done is seen
   task automatic run(input int s, input int n, input bit extra_start, output int cyc);
      cur_s = s; cur_n = n; mon_k = 0; seq_err = 0; out_win = 0;
      @(negedge clk);
      win_base = 16'(s); win_len = 16'(n); start = 1'b1;
      cyc = 0;
      @(posedge clk); cyc++;
      @(negedge clk); start = 1'b0;
      while (!done && cyc < 20000) begin
         if (extra_start && cyc == 5) start = 1'b1; else start = 1'b0;
         @(posedge clk); cyc++;
         @(negedge clk);
      end
      start = 1'b0;
   endtask

   task automatic t_reset();
      check(!busy && !done, "R10 idle after reset", {30'd0, busy, done}, 0);
      check(!fail && fault_map == 0, "R10 result clear after reset", {23'd0, fail, fault_map}, 0);
   endtask

   task automatic t_pass(input int s, input int n, input string tag);
      int cyc;
      bit win_ok;
      init_ram();
      run(s, n, 1'b0, cyc);
      check(cyc == 7 * n + 1, {"R5 run length ", tag}, cyc, 7 * n + 1);
      check(seq_err == 0, {"R1 R2 R3 R4 access order ", tag}, seq_err, 0);
      check(mon_k == 6 * n, {"R4 access count ", tag}, mon_k, 6 * n);
      check(out_win == 0, {"R5 window ", tag}, out_win, 0);
      check(!fail && fault_map == 0, {"R10 pass result ", tag}, {23'd0, fail, fault_map}, 0);
      win_ok = 1;
      for (int a = s; a < s + n; a++) if (ram[a] != 8'h00) win_ok = 0;
      check(win_ok, {"R4 cells end at zero ", tag}, win_ok, 1);
      if (s > 0) check(ram[s - 1] == 8'h5A, {"R5 below untouched ", tag}, ram[s - 1], 8'h5A);
      if (s + n < 256) check(ram[s + n] == 8'h5A, {"R5 above untouched ", tag}, ram[s + n], 8'h5A);
      @(negedge clk);
      check(!done && !busy, {"R10 done one cycle ", tag}, {30'd0, done, busy}, 0);
   endtask

   task automatic t_stuck1();
      int cyc, s, n, m;
      s = 32; n = 16; m = 5;
      init_ram();
      flt_addr = 8'(s + m); st1 = 8'h10;
      run(s, n, 1'b0, cyc);
      check(cyc == n + 2 * m + 3, "R6 abort time in pass two", cyc, n + 2 * m + 3);
      check(fail == 1'b1, "R6 fail flag stuck-at-1", fail, 1);
      check(fault_map == 8'h10, "R7 map stuck-at-1 bit 4", fault_map, 8'h10);
      check(ram[s + m - 1] == 8'hFF, "R2 previous cell written ones", ram[s + m - 1], 8'hFF);
      check(ram[s + m] == 8'h00, "R6 failing cell not written", ram[s + m], 8'h00);
      check(ram[s + m + 1] == 8'h00, "R6 no access after abort", ram[s + m + 1], 8'h00);
      @(negedge clk);
      check(fail && fault_map == 8'h10 && !done, "R10 result held", {23'd0, fail, fault_map}, 9'h110);
      @(negedge clk);
      check(fail && fault_map == 8'h10, "R10 result held two", {23'd0, fail, fault_map}, 9'h110);
   endtask

   task automatic t_stuck0();
      int cyc, s, n, m, j;
      s = 64; n = 12; m = 3; j = n - 1 - m;
      init_ram();
      flt_addr = 8'(s + m); st0 = 8'h10;
      run(s, n, 1'b0, cyc);
      check(cyc == 3 * n + 2 * j + 3, "R6 abort time in pass three", cyc, 3 * n + 2 * j + 3);
      check(fail && fault_map == 8'h10, "R7 map stuck-at-0 bit 4", {23'd0, fail, fault_map}, 9'h110);
      check(ram[s + m + 1] == 8'h00 && ram[s + m - 1] == 8'hFF, "R3 descending state at abort",
            {ram[s + m + 1], ram[s + m - 1]}, 16'h00FF);
   endtask

   task automatic t_couple(input bit victim_high);
      int cyc;
      init_ram();
      cpl_en = 1'b1;
      cpl_agg = victim_high ? 8'd130 : 8'd140;
      cpl_vic = victim_high ? 8'd140 : 8'd130;
      run(128, 16, 1'b0, cyc);
      check(fail && fault_map == 8'hFF, victim_high ? "R7 coupling up" : "R7 coupling down",
            {23'd0, fail, fault_map}, 9'h1FF);
   endtask

   task automatic t_restart();
      int cyc;
      init_ram();
      flt_addr = 8'd0; st1 = 8'h01;
      run(0, 4, 1'b0, cyc);
      check(fail && fault_map == 8'h01, "R7 map stuck-at-1 bit 0", {23'd0, fail, fault_map}, 9'h101);
      init_ram();
      @(negedge clk);
      win_base = 16'd8; win_len = 16'd4; start = 1'b1;
      @(posedge clk);
      @(negedge clk); start = 1'b0;
      check(!fail && fault_map == 0, "R8 start clears result", {23'd0, fail, fault_map}, 0);
      while (!done) @(negedge clk);
   endtask

   task automatic t_ignore_start();
      int cyc;
      init_ram();
      run(200, 10, 1'b1, cyc);
      check(cyc == 71, "R8 start while busy ignored length", cyc, 71);
      check(seq_err == 0 && mon_k == 60, "R8 start while busy ignored order", seq_err, 0);
   endtask

   task automatic t_zero();
      int cyc;
      init_ram();
      run(50, 0, 1'b0, cyc);
      check(cyc == 1, "R9 zero length done time", cyc, 1);
      check(!fail && mon_k == 0, "R9 zero length no access", mon_k, 0);
   endtask

   initial begin
      init_ram();
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_pass(16, 16, "mid");
      t_pass(240, 1, "one cell");
      t_pass(253, 3, "top");
      t_stuck1();
      t_stuck0();
      t_couple(1'b1);
      t_couple(1'b0);
      t_restart();
      t_ignore_start();
      t_zero();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #400000;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule